// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block accepts configuration words from a controller over three wires: a serial data line, a serial shift clock and a load strobe. All three pins are brought into the system clock domain through synchronizer chains. Each rising edge of the serial clock moves one bit into a 19-bit shift register. A rising edge of the load strobe copies the register contents into one of two holding latches. The control bit, which is the last bit shifted in, picks the latch.

The reference latch feeds the reference divider and the phase comparator. It holds a 14-bit reference ratio and three single-bit flags: prescaler ratio select, comparator polarity and monitor output select. The divider latch feeds the feedback divider. It holds a 7-bit swallow count and an 11-bit main count. Every latch write raises a one-cycle pulse on the output for that destination, so downstream counters can reload. The shift path has no enable, so words can be loaded at any time, including while the rest of the synthesizer is powered down.

Top module: `serial_cfg_loader`

## Requirements
- R1: One bit of `cfg_sdata` enters the shift register for each rising edge of `cfg_sclk`. Words are sent most significant bit first. Only the 19 most recent bits are kept, so extra leading bits have no effect.
- R2: Only a rising edge of `cfg_load` writes a latch, and each such edge writes exactly once. Shifting while `cfg_load` is held high, or while it is low, leaves both latches unchanged until the next rising edge.
- R3: If the last bit shifted before the load edge is 1, the reference latch is written. Bits are counted back from that control bit: the 14 bits before it are `ref_ratio` (the LSB is next to the control bit). The bit before those is `presc_small`, the one before that is `cmp_invert`, and the one before that is `mon_select`. A reference word is 18 bits long.
- R4: If the last bit shifted before the load edge is 0, the divider latch is written. Bits are counted back from the control bit: the 7 bits before it are `swallow_cnt` (LSB next to the control bit) and the 11 bits before those are `main_cnt`. A divider word is 19 bits long.
- R5: A write to one latch leaves every output field of the other latch unchanged.
- R6: `ref_loaded` or `div_loaded` is high for exactly one cycle per write, only for the destination written. It is high in the same cycle in which the new field values first appear.
- R7: After reset, every latched field is 0 and both pulses are low.
- R8: A reference write ignores the 19th-oldest bit in the shift register, so whatever was shifted before an 18-bit reference word cannot affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sclk | input | 1 | Serial shift clock (asynchronous) |
| cfg_sdata | input | 1 | Serial data, MSB first (asynchronous) |
| cfg_load | input | 1 | Load strobe, acts on its rising edge (asynchronous) |
| ref_ratio | output | 14 | Reference divider ratio |
| presc_small | output | 1 | 1 selects the smaller prescaler ratio pair |
| cmp_invert | output | 1 | Phase comparator polarity select |
| mon_select | output | 1 | Monitor output select: 1 selects the divided frequencies, 0 selects lock detect |
| swallow_cnt | output | 7 | Swallow counter preset |
| main_cnt | output | 11 | Main programmable counter preset |
| ref_loaded | output | 1 | One-cycle pulse on a reference latch write |
| div_loaded | output | 1 | One-cycle pulse on a divider latch write |

## Verification
Directed words with all-ones, all-zeros and single-bit fields check that every field lands at its stated bit position. They also tell a reversed shift order apart from a correct one. A random mix of reference and divider words, some with random extra leading bits, checks the routing decision against the preserved state of the other latch. It also checks that only the final 19 bits count. Further sequences cover shifting with no load edge, a load strobe held high across a whole word, and a reference word whose stale leading bit is set. These separate edge-triggered loading from level-triggered loading, and show whether the stale bit leaks into a reference write.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int SYNC_STAGES = 2,
  parameter int R_W = 14,
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_sclk,
  input  logic           cfg_sdata,
  input  logic           cfg_load,
  output logic [R_W-1:0] ref_ratio,
  output logic           presc_small,
  output logic           cmp_invert,
  output logic           mon_select,
  output logic [A_W-1:0] swallow_cnt,
  output logic [N_W-1:0] main_cnt,
  output logic           ref_loaded,
  output logic           div_loaded
);

  localparam int REF_W = R_W + 3;
  localparam int DIV_W = A_W + N_W;
  localparam int SR_W  = ((REF_W > DIV_W) ? REF_W : DIV_W) + 1;

  logic [SYNC_STAGES:0] sclk_q, sdat_q, load_q;
  logic [SR_W-1:0]      sr;
  logic                 sclk_rise, load_rise, bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdat_q <= '0;
      load_q <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], cfg_sclk};
      sdat_q <= {sdat_q[SYNC_STAGES-1:0], cfg_sdata};
      load_q <= {load_q[SYNC_STAGES-1:0], cfg_load};
    end
  end

  assign sclk_rise = sclk_q[SYNC_STAGES-1] & ~sclk_q[SYNC_STAGES];
  assign load_rise = load_q[SYNC_STAGES-1] & ~load_q[SYNC_STAGES];
  assign bit_in    = sdat_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (sclk_rise) sr <= {sr[SR_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ratio   <= '0;
      presc_small <= 1'b0;
      cmp_invert  <= 1'b0;
      mon_select  <= 1'b0;
      swallow_cnt <= '0;
      main_cnt    <= '0;
      ref_loaded  <= 1'b0;
      div_loaded  <= 1'b0;
    end else begin
      ref_loaded <= load_rise & sr[0];
      div_loaded <= load_rise & ~sr[0];
      if (load_rise) begin
        if (sr[0]) begin
          ref_ratio   <= sr[R_W:1];
          presc_small <= sr[R_W+1];
          cmp_invert  <= sr[R_W+2];
          mon_select  <= sr[R_W+3];
        end else begin
          swallow_cnt <= sr[A_W:1];
          main_cnt    <= sr[A_W+N_W:A_W+1];
        end
      end
    end
  end

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sr)); // R1
  AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sr[0] == $past(bit_in)); // R1
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_loaded |-> $stable({ref_ratio, presc_small, cmp_invert, mon_select})); // R5
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_loaded |-> $stable({swallow_cnt, main_cnt})); // R5
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_loaded, div_loaded})); // R6
  AST_REF_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_loaded |=> !ref_loaded); // R6
  AST_DIV_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    div_loaded |=> !div_loaded); // R6
  AST_WRITE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_loaded || div_loaded) |-> $past(load_q[SYNC_STAGES-1]) && !$past(load_q[SYNC_STAGES])); // R2

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_sclk = 0, cfg_sdata = 0, cfg_load = 0;
  logic [13:0] ref_ratio;
  logic presc_small, cmp_invert, mon_select;
  logic [6:0] swallow_cnt;
  logic [10:0] main_cnt;
  logic ref_loaded, div_loaded;

  int checks = 0, failures = 0;
  int ref_pulses = 0, div_pulses = 0;

  logic [18:0] m_sr = '0;
  logic [16:0] e_ref = '0;
  logic [17:0] e_div = '0;
  int e_refp = 0, e_divp = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .cfg_load(cfg_load), .ref_ratio(ref_ratio), .presc_small(presc_small),
    .cmp_invert(cmp_invert), .mon_select(mon_select), .swallow_cnt(swallow_cnt),
    .main_cnt(main_cnt), .ref_loaded(ref_loaded), .div_loaded(div_loaded));

  always @(negedge clk) begin
    if (ref_loaded) ref_pulses++;
    if (div_loaded) div_pulses++;
    if (ref_loaded && div_loaded) begin
      checks++; failures++;
      $display("FAIL R6 both pulses high act=11 exp=one");
    end
  end

  function automatic logic [17:0] ref_word(logic [13:0] r, logic sw, logic fc, logic lds);
    return {lds, fc, sw, r, 1'b1};
  endfunction

  function automatic logic [18:0] div_word(logic [6:0] a, logic [10:0] n);
    return {n, a, 1'b0};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(logic b);
    cfg_sdata = b;
    tick(2);
    cfg_sclk = 1;
    tick(HOLD);
    cfg_sclk = 0;
    tick(HOLD);
    m_sr = {m_sr[17:0], b};
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic model_load();
    if (m_sr[0]) begin e_ref = m_sr[17:1]; e_refp++; end
    else begin e_div = m_sr[18:1]; e_divp++; end
  endtask

  task automatic pulse_load();
    tick(2);
    cfg_load = 1;
    tick(HOLD);
    cfg_load = 0;
    model_load();
    tick(8);
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    checks++;
    if ({mon_select, cmp_invert, presc_small, ref_ratio} !== e_ref) begin
      failures++;
      $display("FAIL %s ref act=%h exp=%h", req, {mon_select, cmp_invert, presc_small, ref_ratio}, e_ref);
    end
    checks++;
    if ({main_cnt, swallow_cnt} !== e_div) begin
      failures++;
      $display("FAIL %s div act=%h exp=%h", req, {main_cnt, swallow_cnt}, e_div);
    end
    checks++;
    if (ref_pulses != e_refp || div_pulses != e_divp) begin
      failures++;
      $display("FAIL R6 %s pulses act=%0d/%0d exp=%0d/%0d", req, ref_pulses, div_pulses, e_refp, e_divp);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1;
    tick(2);
    check_all("R7");

    send_bits(ref_word(14'h3FFF, 1, 0, 1), 18); pulse_load(); check_all("R3");
    send_bits(ref_word(14'h0001, 0, 1, 0), 18); pulse_load(); check_all("R3");
    send_bits(div_word(7'h7F, 11'h000), 19); pulse_load(); check_all("R4");
    send_bits(div_word(7'h01, 11'h400), 19); pulse_load(); check_all("R5");

    // r1_ extra sclk pulses without load do nothing
    send_bits(32'h0001_2345, 19); check_all("R2");

    // R8: stale bit before an 18-bit reference word is 1
    send_bit(1);
    send_bits(ref_word(14'h1555, 1, 1, 0), 18); pulse_load(); check_all("R8");

    // R2: load held high while a new word is shifted
    send_bits(div_word(7'h2A, 11'h155), 19);
    tick(2);
    cfg_load = 1;
    tick(HOLD);
    model_load();
    send_bits(div_word(7'h55, 11'h2AA), 19);
    check_all("R2");
    cfg_load = 0;
    tick(8);
    check_all("R2");
    pulse_load(); check_all("R2");

    for (int k = 0; k < 30; k++) begin
      int pre = $urandom_range(0, 5);
      if (pre > 0) send_bits($urandom, pre);
      if ($urandom_range(0, 1) == 1)
        send_bits(ref_word(14'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)), 18);
      else
        send_bits(div_word(7'($urandom), 11'($urandom)), 19);
      pulse_load();
      check_all("R1");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule